// File: doc/BRIEF.md
# Per-Warp SIMT Divergence and Reconvergence Stack

This block follows the control flow of one warp in a SIMT core. It keeps a private stack of (PC, reconvergence PC, lane mask) entries, and the entry on top decides which instruction address and which lanes are handed to instruction fetch next. After each instruction of the warp resolves, the core reports one update on a valid/ready channel. The update says whether the instruction was a branch, and gives the per-lane taken bits, the branch target, the fall-through (sequential next) address and the immediate post-dominator address where diverged paths meet again.

When the active lanes disagree on a branch, the top entry is kept as the rejoin entry with its full mask, now parked at the reconvergence address. The not-taken group and then the taken group are pushed on top of it, so the taken group runs first. When the top path's next PC equals its reconvergence PC, that entry is popped in the same cycle and the next group (or the rejoined full mask) takes over. Lanes that finish early simply wait below on the stack. Divergence inside a diverged path stacks further entries. Stack overflow or underflow sets a sticky error and freezes all state.

Back-pressure: `upd_ready` is high whenever no error has been recorded, and an update is accepted on a rising clock edge where `upd_valid` and `upd_ready` are both high. After an error `upd_ready` stays low until reset. Updates offered while `upd_ready` is low are dropped and change nothing. The fetch outputs are plain registered outputs. `fetch_valid` is high exactly when no error has been recorded.

Top module: `simt_reconv_stack`

## Requirements
- R1: A synchronous active-high reset leaves one entry covering all lanes at START_PC: fetch_pc = START_PC, fetch_mask all ones, err = 0, fetch_valid = 1, upd_ready = 1. The bottom entry's reconvergence PC is all ones.
- R2: An accepted non-branch update (upd_branch = 0) sets fetch_pc to upd_next from the next clock edge, and leaves fetch_mask unchanged, unless a pop (R5) applies.
- R3: An accepted branch on which all active lanes agree pushes nothing. fetch_pc becomes upd_target if every active lane is taken (upd_taken bit i = 1 means lane i taken), or upd_next if none is. The mask is unchanged.
- R4: An accepted diverging branch makes the taken group current from the next edge: fetch_pc = upd_target and fetch_mask = upd_taken AND the previous mask.
- R5: When the next PC of the top path equals that entry's reconvergence PC, the entry is popped in the same cycle, and the entry below it (for example the not-taken group at upd_next) becomes current.
- R6: After both groups reach the reconvergence PC, the rejoin entry resumes at that PC with the full mask it had before the branch.
- R7: Divergence inside a diverged path pushes further entries and unwinds correctly. When the inner reconvergence PC equals the enclosing entry's reconvergence PC, the inner groups replace that entry instead of stacking on it.
- R8: A group whose start address equals upd_reconv is not pushed. Only the other group runs before the rejoin.
- R9: A push beyond DEPTH entries sets err, leaves fetch_pc and fetch_mask unchanged and drops fetch_valid. err stays set until reset.
- R10: A pop of the bottom entry (next PC equal to all ones at stack depth one) sets err and leaves fetch_pc and fetch_mask unchanged.
- R11: upd_ready is low while err is set. Updates offered then change neither fetch_pc nor fetch_mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| upd_valid | input | 1 | Resolved-instruction update offered |
| upd_ready | output | 1 | Update may be accepted (low after error) |
| upd_branch | input | 1 | Update is a conditional branch |
| upd_taken | input | LANES | Per-lane branch outcome, 1 = taken |
| upd_target | input | AW | Branch target address |
| upd_next | input | AW | Fall-through / sequential next address |
| upd_reconv | input | AW | Reconvergence (post-dominator) address |
| fetch_valid | output | 1 | Fetch request valid (no error) |
| fetch_pc | output | AW | Next PC to fetch for this warp |
| fetch_mask | output | LANES | Active lanes for that fetch |
| err | output | 1 | Sticky overflow/underflow flag |

## Verification
Every result of an accepted update, whether a move, push, pop or fault, shows at the fetch outputs and err one clock edge after acceptance, with no extra latency. upd_ready follows err with no further delay. The driver task records the expected PC, mask and error state just after the edge that takes the update. The monitor compares them at the following falling edge, so each result is sampled exactly one cycle after its stimulus and away from the active edge.

// File: rtl/simt_rs_pkg.sv
package simt_rs_pkg;
  typedef enum logic [1:0] {
    RS_MOVE  = 2'd0,
    RS_POP   = 2'd1,
    RS_SPLIT = 2'd2,
    RS_FAULT = 2'd3
  } rs_op_e;
  localparam int unsigned RS_PORTS = 3;
endpackage

// File: rtl/simt_rs_split.sv
module simt_rs_split #(
  parameter int unsigned LANES = 8
) (
  input  logic [LANES-1:0] act_mask,
  input  logic [LANES-1:0] taken,
  input  logic             is_branch,
  output logic [LANES-1:0] t_mask,
  output logic [LANES-1:0] nt_mask,
  output logic             all_taken,
  output logic             none_taken
);
  always_comb begin
    t_mask     = is_branch ? (taken & act_mask) : '0;
    nt_mask    = act_mask & ~t_mask;
    all_taken  = is_branch && (t_mask == act_mask);
    none_taken = (t_mask == '0);
  end
endmodule

// File: rtl/simt_rs_decide.sv
module simt_rs_decide
  import simt_rs_pkg::*;
#(
  parameter int unsigned LANES = 8,
  parameter int unsigned AW    = 16,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned SPW  = $clog2(DEPTH + 1),
  localparam int unsigned IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                            accept,
  input  logic [SPW-1:0]                  sp,
  input  logic [AW-1:0]                   top_rpc,
  input  logic [LANES-1:0]                top_mask,
  input  logic                            is_branch,
  input  logic [LANES-1:0]                t_mask,
  input  logic [LANES-1:0]                nt_mask,
  input  logic                            all_taken,
  input  logic                            none_taken,
  input  logic [AW-1:0]                   tgt,
  input  logic [AW-1:0]                   nxt,
  input  logic [AW-1:0]                   rcv,
  output rs_op_e                          op,
  output logic [RS_PORTS-1:0]             wr_en,
  output logic [RS_PORTS-1:0][IW-1:0]     wr_idx,
  output logic [RS_PORTS-1:0][AW-1:0]     wr_pc,
  output logic [RS_PORTS-1:0][AW-1:0]     wr_rpc,
  output logic [RS_PORTS-1:0][LANES-1:0]  wr_mask,
  output logic [SPW-1:0]                  sp_next,
  output logic                            fault
);
  logic [SPW-1:0] top_ix;
  logic           push_nt, push_t, diverge, merge;
  logic [1:0]     cnt;
  logic [SPW:0]   base, fill;
  logic [AW-1:0]  mv_pc;

  always_comb begin
    top_ix  = sp - SPW'(1);
    push_nt = (nxt != rcv);
    push_t  = (tgt != rcv);
    cnt     = {1'b0, push_nt} + {1'b0, push_t};
    diverge = is_branch && !all_taken && !none_taken && (cnt != 2'd0);
    merge   = (rcv == top_rpc);
    base    = merge ? {1'b0, top_ix} : {1'b0, sp};
    fill    = base + (SPW+1)'(cnt);
    if (!is_branch || none_taken) mv_pc = nxt;
    else if (all_taken)           mv_pc = tgt;
    else                          mv_pc = rcv;
  end

  always_comb begin
    op      = RS_MOVE;
    wr_en   = '0;
    wr_idx  = '0;
    wr_pc   = '0;
    wr_rpc  = '0;
    wr_mask = '0;
    sp_next = sp;
    fault   = 1'b0;
    if (accept) begin
      if (diverge) begin
        if (fill > (SPW+1)'(DEPTH)) begin
          op    = RS_FAULT;
          fault = 1'b1;
        end else begin
          op         = RS_SPLIT;
          wr_en[0]   = !merge;
          wr_idx[0]  = IW'(top_ix);
          wr_pc[0]   = rcv;
          wr_rpc[0]  = top_rpc;
          wr_mask[0] = top_mask;
          wr_en[1]   = 1'b1;
          wr_idx[1]  = IW'(base);
          wr_pc[1]   = push_nt ? nxt : tgt;
          wr_rpc[1]  = rcv;
          wr_mask[1] = push_nt ? nt_mask : t_mask;
          wr_en[2]   = push_nt && push_t;
          wr_idx[2]  = IW'(base + (SPW+1)'(1));
          wr_pc[2]   = tgt;
          wr_rpc[2]  = rcv;
          wr_mask[2] = t_mask;
          sp_next    = fill[SPW-1:0];
        end
      end else if (mv_pc == top_rpc) begin
        if (sp == SPW'(1)) begin
          op    = RS_FAULT;
          fault = 1'b1;
        end else begin
          op      = RS_POP;
          sp_next = top_ix;
        end
      end else begin
        op         = RS_MOVE;
        wr_en[0]   = 1'b1;
        wr_idx[0]  = IW'(top_ix);
        wr_pc[0]   = mv_pc;
        wr_rpc[0]  = top_rpc;
        wr_mask[0] = top_mask;
      end
    end
  end
endmodule

// File: rtl/simt_rs_store.sv
module simt_rs_store
  import simt_rs_pkg::*;
#(
  parameter int unsigned LANES    = 8,
  parameter int unsigned AW       = 16,
  parameter int unsigned DEPTH    = 8,
  parameter logic [AW-1:0] START_PC = '0,
  localparam int unsigned SPW     = $clog2(DEPTH + 1),
  localparam int unsigned IW      = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [RS_PORTS-1:0]             wr_en,
  input  logic [RS_PORTS-1:0][IW-1:0]     wr_idx,
  input  logic [RS_PORTS-1:0][AW-1:0]     wr_pc,
  input  logic [RS_PORTS-1:0][AW-1:0]     wr_rpc,
  input  logic [RS_PORTS-1:0][LANES-1:0]  wr_mask,
  input  logic [SPW-1:0]                  sp_next,
  input  logic                            fault,
  output logic [SPW-1:0]                  sp,
  output logic [AW-1:0]                   top_pc,
  output logic [AW-1:0]                   top_rpc,
  output logic [LANES-1:0]                top_mask,
  output logic                            err_q
);
  logic [AW-1:0]    pc_q   [DEPTH];
  logic [AW-1:0]    rpc_q  [DEPTH];
  logic [LANES-1:0] mask_q [DEPTH];
  logic [IW-1:0]    top_ix;

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst) begin
        pc_q[e]   <= (e == 0) ? START_PC : '0;
        rpc_q[e]  <= (e == 0) ? '1 : '0;
        mask_q[e] <= (e == 0) ? '1 : '0;
      end else begin
        for (int p = 0; p < RS_PORTS; p++) begin
          if (wr_en[p] && (wr_idx[p] == IW'(e))) begin
            pc_q[e]   <= wr_pc[p];
            rpc_q[e]  <= wr_rpc[p];
            mask_q[e] <= wr_mask[p];
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sp    <= SPW'(1);
      err_q <= 1'b0;
    end else begin
      sp <= sp_next;
      if (fault) err_q <= 1'b1;
    end
  end

  always_comb begin
    top_ix   = IW'(sp - SPW'(1));
    top_pc   = pc_q[top_ix];
    top_rpc  = rpc_q[top_ix];
    top_mask = mask_q[top_ix];
  end
endmodule

// File: rtl/simt_reconv_stack.sv
module simt_reconv_stack
  import simt_rs_pkg::*;
#(
  parameter int unsigned LANES    = 8,
  parameter int unsigned AW       = 16,
  parameter int unsigned DEPTH    = 8,
  parameter logic [AW-1:0] START_PC = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             upd_valid,
  output logic             upd_ready,
  input  logic             upd_branch,
  input  logic [LANES-1:0] upd_taken,
  input  logic [AW-1:0]    upd_target,
  input  logic [AW-1:0]    upd_next,
  input  logic [AW-1:0]    upd_reconv,
  output logic             fetch_valid,
  output logic [AW-1:0]    fetch_pc,
  output logic [LANES-1:0] fetch_mask,
  output logic             err
);
  localparam int unsigned SPW = $clog2(DEPTH + 1);
  localparam int unsigned IW  = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic                           accept, fault, all_taken, none_taken;
  logic [SPW-1:0]                 sp, sp_next;
  logic [AW-1:0]                  top_pc, top_rpc;
  logic [LANES-1:0]               top_mask, t_mask, nt_mask;
  logic [RS_PORTS-1:0]            wr_en;
  logic [RS_PORTS-1:0][IW-1:0]    wr_idx;
  logic [RS_PORTS-1:0][AW-1:0]    wr_pc, wr_rpc;
  logic [RS_PORTS-1:0][LANES-1:0] wr_mask;
  rs_op_e                         op;

  assign upd_ready   = !err;
  assign accept      = upd_valid && upd_ready;
  assign fetch_valid = !err;
  assign fetch_pc    = top_pc;
  assign fetch_mask  = top_mask;

  simt_rs_split #(.LANES(LANES)) u_split (
    .act_mask(top_mask), .taken(upd_taken), .is_branch(upd_branch),
    .t_mask(t_mask), .nt_mask(nt_mask),
    .all_taken(all_taken), .none_taken(none_taken)
  );

  simt_rs_decide #(.LANES(LANES), .AW(AW), .DEPTH(DEPTH)) u_decide (
    .accept(accept), .sp(sp), .top_rpc(top_rpc), .top_mask(top_mask),
    .is_branch(upd_branch), .t_mask(t_mask), .nt_mask(nt_mask),
    .all_taken(all_taken), .none_taken(none_taken),
    .tgt(upd_target), .nxt(upd_next), .rcv(upd_reconv),
    .op(op), .wr_en(wr_en), .wr_idx(wr_idx), .wr_pc(wr_pc),
    .wr_rpc(wr_rpc), .wr_mask(wr_mask), .sp_next(sp_next), .fault(fault)
  );

  simt_rs_store #(.LANES(LANES), .AW(AW), .DEPTH(DEPTH), .START_PC(START_PC)) u_store (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_pc(wr_pc),
    .wr_rpc(wr_rpc), .wr_mask(wr_mask), .sp_next(sp_next), .fault(fault),
    .sp(sp), .top_pc(top_pc), .top_rpc(top_rpc), .top_mask(top_mask),
    .err_q(err)
  );

  logic unused_op;
  assign unused_op = ^op;
endmodule

// File: rtl/simt_rs_check.sv
module simt_rs_check #(
  parameter int unsigned LANES    = 8,
  parameter int unsigned AW       = 16,
  parameter logic [AW-1:0] START_PC = '0
) (
  input logic             clk,
  input logic             rst,
  input logic             upd_valid,
  input logic             upd_ready,
  input logic             upd_branch,
  input logic [LANES-1:0] upd_taken,
  input logic [AW-1:0]    upd_target,
  input logic [AW-1:0]    upd_next,
  input logic [AW-1:0]    upd_reconv,
  input logic             fetch_valid,
  input logic [AW-1:0]    fetch_pc,
  input logic [LANES-1:0] fetch_mask,
  input logic             err
);
  a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (fetch_pc == START_PC && fetch_mask == '1 && !err));

  a_r9_err_sticky: assert property (@(posedge clk) disable iff (rst)
    err |=> err);

  a_r9_fault_freezes: assert property (@(posedge clk) disable iff (rst)
    $rose(err) |-> ($stable(fetch_pc) && $stable(fetch_mask)));

  a_r11_no_accept_when_busy: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && !upd_ready) |=> ($stable(fetch_pc) && $stable(fetch_mask)));

  a_r4_taken_first: assert property (@(posedge clk) disable iff (rst)
    (upd_valid && upd_ready && upd_branch && upd_target != upd_reconv &&
     (upd_taken & fetch_mask) != '0 && (~upd_taken & fetch_mask) != '0)
    |=> (err || (fetch_pc == $past(upd_target) &&
                 fetch_mask == $past(upd_taken & fetch_mask))));

  a_r3_mask_nonzero: assert property (@(posedge clk) disable iff (rst)
    fetch_valid |-> (fetch_mask != '0));
endmodule

bind simt_reconv_stack simt_rs_check #(.LANES(LANES), .AW(AW), .START_PC(START_PC)) u_chk (
  .clk(clk), .rst(rst), .upd_valid(upd_valid), .upd_ready(upd_ready),
  .upd_branch(upd_branch), .upd_taken(upd_taken), .upd_target(upd_target),
  .upd_next(upd_next), .upd_reconv(upd_reconv), .fetch_valid(fetch_valid),
  .fetch_pc(fetch_pc), .fetch_mask(fetch_mask), .err(err)
);

// File: tb/simt_reconv_stack_test.sv
`timescale 1ns/1ps
module simt_reconv_stack_test;
  localparam int unsigned LANES = 8;
  localparam int unsigned AW    = 16;
  localparam int unsigned DEPTH = 5;
  localparam logic [AW-1:0] START = 16'h0100;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic upd_valid = 1'b0, upd_branch = 1'b0;
  logic [LANES-1:0] upd_taken = '0;
  logic [AW-1:0] upd_target = '0, upd_next = '0, upd_reconv = '0;
  logic upd_ready, fetch_valid, err;
  logic [AW-1:0] fetch_pc;
  logic [LANES-1:0] fetch_mask;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [AW-1:0]    pc;
    logic [LANES-1:0] mask;
    logic             e;
    string            tag;
  } exp_t;
  exp_t sb[$];

  always #10 clk = ~clk;

  simt_reconv_stack #(.LANES(LANES), .AW(AW), .DEPTH(DEPTH), .START_PC(START)) uut (
    .clk(clk), .rst(rst), .upd_valid(upd_valid), .upd_ready(upd_ready),
    .upd_branch(upd_branch), .upd_taken(upd_taken), .upd_target(upd_target),
    .upd_next(upd_next), .upd_reconv(upd_reconv), .fetch_valid(fetch_valid),
    .fetch_pc(fetch_pc), .fetch_mask(fetch_mask), .err(err)
  );

  task automatic compare(string tag, logic [AW-1:0] pc, logic [LANES-1:0] m, logic e);
    checks++;
    if (fetch_pc !== pc || fetch_mask !== m || err !== e ||
        fetch_valid !== !e || upd_ready !== !e) begin
      errors++;
      $display("FAIL %s: pc=%h mask=%h err=%b valid=%b ready=%b expected pc=%h mask=%h err=%b",
               tag, fetch_pc, fetch_mask, err, fetch_valid, upd_ready, pc, m, e);
    end
  endtask

  // monitor: one expectation per accepted-or-offered update, due one edge later
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t x;
      x = sb.pop_front();
      compare(x.tag, x.pc, x.mask, x.e);
    end
  end

  task automatic drive(logic br, logic [LANES-1:0] tk, logic [AW-1:0] tg,
                       logic [AW-1:0] nx, logic [AW-1:0] rc,
                       logic [AW-1:0] epc, logic [LANES-1:0] em, logic ee, string tag);
    exp_t x;
    @(negedge clk);
    upd_valid = 1'b1; upd_branch = br; upd_taken = tk;
    upd_target = tg; upd_next = nx; upd_reconv = rc;
    @(posedge clk);
    #1;
    upd_valid = 1'b0;
    x.pc = epc; x.mask = em; x.e = ee; x.tag = tag;
    sb.push_back(x);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    compare("R1 reset state", START, 8'hFF, 1'b0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    drive(0, 8'h00, 16'h0000, 16'h0101, 16'h0000, 16'h0101, 8'hFF, 0, "R2 sequential");
    drive(1, 8'hFF, 16'h0200, 16'h0102, 16'h0300, 16'h0200, 8'hFF, 0, "R3 all taken");
    drive(1, 8'h00, 16'h0300, 16'h0201, 16'h0400, 16'h0201, 8'hFF, 0, "R3 none taken");
    drive(1, 8'h0F, 16'h0210, 16'h0202, 16'h0220, 16'h0210, 8'h0F, 0, "R4 taken first");
    drive(1, 8'h03, 16'h0230, 16'h0211, 16'h0218, 16'h0230, 8'h03, 0, "R7 nested taken");
    drive(0, 8'h00, 16'h0000, 16'h0218, 16'h0000, 16'h0211, 8'h0C, 0, "R7 nested not-taken");
    drive(0, 8'h00, 16'h0000, 16'h0218, 16'h0000, 16'h0218, 8'h0F, 0, "R7 inner rejoin");
    drive(0, 8'h00, 16'h0000, 16'h0220, 16'h0000, 16'h0202, 8'hF0, 0, "R5 not-taken path");
    drive(1, 8'h30, 16'h0208, 16'h0203, 16'h0208, 16'h0203, 8'hC0, 0, "R8 skip empty taken");
    drive(0, 8'h00, 16'h0000, 16'h0208, 16'h0000, 16'h0208, 8'hF0, 0, "R8 rejoin");
    drive(0, 8'h00, 16'h0000, 16'h0220, 16'h0000, 16'h0220, 8'hFF, 0, "R6 full mask");
    drive(1, 8'h01, 16'h0300, 16'h0221, 16'h0400, 16'h0300, 8'h01, 0, "R4 single lane");
    drive(0, 8'h00, 16'h0000, 16'h0400, 16'h0000, 16'h0221, 8'hFE, 0, "R5 pop to not-taken");
    drive(1, 8'h06, 16'h0310, 16'h0222, 16'h0400, 16'h0310, 8'h06, 0, "R7 shared rejoin");
    drive(0, 8'h00, 16'h0000, 16'h0400, 16'h0000, 16'h0222, 8'hF8, 0, "R7 shared rejoin nt");
    drive(0, 8'h00, 16'h0000, 16'h0400, 16'h0000, 16'h0400, 8'hFF, 0, "R6 rejoin after shared");
    drive(1, 8'h0F, 16'h0500, 16'h0401, 16'h0600, 16'h0500, 8'h0F, 0, "R4 depth 3");
    drive(1, 8'h03, 16'h0510, 16'h0501, 16'h0520, 16'h0510, 8'h03, 0, "R7 depth 5");
    drive(1, 8'h01, 16'h0530, 16'h0511, 16'h0540, 16'h0510, 8'h03, 1, "R9 overflow");
    drive(0, 8'h00, 16'h0000, 16'h0777, 16'h0000, 16'h0510, 8'h03, 1, "R11 ignored when not ready");
    drive(0, 8'h00, 16'h0000, 16'h0778, 16'h0000, 16'h0510, 8'h03, 1, "R9 sticky");
    @(negedge clk);
    do_reset();
    drive(0, 8'h00, 16'h0000, 16'hFFFF, 16'h0000, START, 8'hFF, 1, "R10 underflow");
    @(negedge clk);
    @(negedge clk);
    compare("R10 frozen after underflow", START, 8'hFF, 1'b1);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule